// File: doc/BRIEF.md
# Half-Table Inverse-Mod-Prime Byte Substitution Unit

This unit replaces an input byte with its multiplicative inverse modulo the prime 2^W+1, which is 257 for the default 8-bit width. Byte value 0 stands for 2^W, which is congruent to -1 and so is its own inverse. The unit keeps only one member of each inverse pair. Slot x holds a value only when the inverse of x is larger than x. All other slots are marked empty by a per-slot valid bit. The table is built from constant logic, and there is no memory macro.

A request carries one byte and is accepted when `req_valid` and `req_ready` are both high at a clock edge. If the byte's own slot is filled, or the byte is one of the two self-inverse values, the result is registered at the accepting edge. Otherwise the byte's slot is empty, and the unit walks the list of filled slots in ascending slot order, making one comparison per clock. The first filled slot whose stored value equals the byte supplies the answer: its position is the result. The response is a single-cycle `rsp_valid` pulse with the result on `rsp_data`. It has no backpressure.

Top module: `rrsub_unit`

## Requirements
- R1: Reset is asynchronous and active low. During reset and on release, `req_ready` is 1 and `rsp_valid` is 0. A reset during a search abandons that search, and no response for it ever appears.
- R2: Every response satisfies x·y ≡ 1 mod 2^W+1, where x is the accepted byte, y is `rsp_data`, and the byte value 0 is read as 2^W.
- R3: Input 0x00 returns 0x00 and input 0x01 returns 0x01. Both are fixed rules that need no table slot.
- R4: Slot x is filled exactly when x ≥ 2 and inverse(x) > x, which gives 2^(W-1)-1 filled slots. A filled-slot input, or input 0x00 or 0x01, gives `rsp_valid` high in the cycle right after the accepting edge. `req_ready` stays high, so such requests can follow one another on every cycle.
- R5: For any other input x, `req_ready` is low from the accepting edge until the response. `rsp_valid` is high in the cycle that follows the (k+1)-th edge after the accepting edge. Here k is the number of filled slots whose position is below inverse(x). This is never more than 2^(W-1)-1 edges.
- R6: Substituting the result again returns the original byte, for all 2^W inputs.
- R7: Each accepted request produces exactly one response. No response appears without an accepted request.
- R8: A request presented while `req_ready` is low is ignored. It produces no response and does not change the result of the search in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request byte present |
| req_data | input | W | Byte to substitute |
| req_ready | output | 1 | Unit can accept a request |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_data | output | W | Inverse of the accepted byte |

## Verification
The hardest case to reach is the tail of the reverse search. An input whose partner sits in one of the last filled slots keeps the unit busy for about 127 cycles. Requests that arrive during that window must be dropped, and a reset inside it must abandon the search cleanly. The bench computes the exact latency of every input from its own brute-force inverse table. It picks the input with the longest search, holds a competing request against it while the search runs, and in a separate run asserts reset midway through the same search. Full ascending and descending sweeps, plus a double-substitution pass, cover every slot both as a hit and as a search target.

// File: rtl/rrsub_pkg.sv
package rrsub_pkg;

   typedef enum logic [0:0] {
      ST_IDLE   = 1'b0,
      ST_SEARCH = 1'b1
   } rrsub_state_e;

   // byte value 0 encodes 2**w
   function automatic int unsigned byte_to_num(int unsigned b, int unsigned w);
      return (b == 0) ? (32'd1 << w) : b;
   endfunction

   function automatic int unsigned num_to_byte(int unsigned n, int unsigned w);
      return (n == (32'd1 << w)) ? 32'd0 : n;
   endfunction

   // inverse by Fermat exponentiation n**(p-2) mod p
   function automatic int unsigned mod_inv_num(int unsigned n, int unsigned p);
      int unsigned r;
      int unsigned b;
      int unsigned e;
      r = 1;
      b = n % p;
      e = p - 2;
      while (e > 0) begin
         if (e[0]) r = (r * b) % p;
         b = (b * b) % p;
         e = e >> 1;
      end
      return r;
   endfunction

   function automatic int unsigned subst_ref(int unsigned b, int unsigned w);
      int unsigned p;
      p = (32'd1 << w) + 1;
      return num_to_byte(mod_inv_num(byte_to_num(b, w), p), w);
   endfunction

   // a slot is filled when it is the smaller member of its pair
   function automatic bit slot_holds(int unsigned b, int unsigned w);
      return (b >= 2) && (subst_ref(b, w) > b);
   endfunction

   function automatic bit resolves_direct(int unsigned b, int unsigned w);
      return (b < 2) || slot_holds(b, w);
   endfunction

   function automatic bit is_inverse_pair(int unsigned a, int unsigned b, int unsigned w);
      int unsigned p;
      p = (32'd1 << w) + 1;
      return ((byte_to_num(a, w) * byte_to_num(b, w)) % p) == 1;
   endfunction

endpackage

// File: rtl/rrsub_slot_table.sv
module rrsub_slot_table #(
   parameter int W = 8
) (
   input  logic [W-1:0] addr_i,
   output logic         direct_o,
   output logic [W-1:0] value_o
);
   localparam int SLOTS = 1 << W;

   logic [SLOTS-1:0] held;
   logic [W-1:0]     held_val [SLOTS];

   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         localparam bit          HOLD  = rrsub_pkg::slot_holds(s, W);
         localparam int unsigned VAL_U = rrsub_pkg::subst_ref(s, W);
         assign held[s]     = HOLD;
         assign held_val[s] = HOLD ? VAL_U[W-1:0] : '0;
      end
   endgenerate

   always_comb begin
      if (addr_i[W-1:1] == '0) begin
         direct_o = 1'b1;
         value_o  = addr_i;
      end else begin
         direct_o = held[addr_i];
         value_o  = held_val[addr_i];
      end
   end

endmodule

// File: rtl/rrsub_pair_list.sv
module rrsub_pair_list #(
   parameter int W = 8
) (
   input  logic [W-2:0] idx_i,
   output logic [W-1:0] pos_o,
   output logic [W-1:0] val_o
);
   localparam int LIST_N = (1 << (W - 1)) - 1;
   localparam int IDX_W  = W - 1;
   localparam int DEPTH  = 1 << IDX_W;

   function automatic logic [LIST_N*W-1:0] build_positions();
      logic [LIST_N*W-1:0] acc;
      int k;
      acc = '0;
      k   = 0;
      for (int x = 2; x < (1 << W); x++) begin
         if (rrsub_pkg::slot_holds(x, W) && k < LIST_N) begin
            acc[k*W +: W] = x[W-1:0];
            k++;
         end
      end
      return acc;
   endfunction

   localparam logic [LIST_N*W-1:0] POS_ALL = build_positions();

   logic [W-1:0] pos_arr [DEPTH];
   logic [W-1:0] val_arr [DEPTH];

   generate
      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         if (e < LIST_N) begin : g_used
            localparam int unsigned POS_U = 32'(POS_ALL[e*W +: W]);
            localparam int unsigned VAL_U = rrsub_pkg::subst_ref(POS_U, W);
            assign pos_arr[e] = POS_U[W-1:0];
            assign val_arr[e] = VAL_U[W-1:0];
         end else begin : g_pad
            assign pos_arr[e] = '0;
            assign val_arr[e] = '0;
         end
      end
   endgenerate

   assign pos_o = pos_arr[idx_i];
   assign val_o = val_arr[idx_i];

endmodule

// File: rtl/rrsub_search_ctrl.sv
module rrsub_search_ctrl #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid_i,
   input  logic [W-1:0] req_data_i,
   output logic         req_ready_o,
   input  logic         direct_i,
   input  logic [W-1:0] direct_val_i,
   output logic [W-2:0] list_idx_o,
   input  logic [W-1:0] list_pos_i,
   input  logic [W-1:0] list_val_i,
   output logic         rsp_valid_o,
   output logic [W-1:0] rsp_data_o
);
   import rrsub_pkg::*;

   localparam int LIST_N = (1 << (W - 1)) - 1;
   localparam int IDX_W  = W - 1;
   localparam int LAST_I = LIST_N - 1;

   rrsub_state_e state_q;
   logic [W-1:0]     key_q;
   logic [IDX_W-1:0] idx_q;
   logic             rsp_v_q;
   logic [W-1:0]     rsp_d_q;
   logic             match;
   logic             at_end;

   assign match  = (list_val_i == key_q);
   assign at_end = (idx_q == LAST_I[IDX_W-1:0]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         key_q   <= '0;
         idx_q   <= '0;
         rsp_v_q <= 1'b0;
         rsp_d_q <= '0;
      end else begin
         rsp_v_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (req_valid_i) begin
                  if (direct_i) begin
                     rsp_v_q <= 1'b1;
                     rsp_d_q <= direct_val_i;
                  end else begin
                     key_q   <= req_data_i;
                     idx_q   <= '0;
                     state_q <= ST_SEARCH;
                  end
               end
            end
            ST_SEARCH: begin
               if (match || at_end) begin
                  rsp_v_q <= 1'b1;
                  rsp_d_q <= list_pos_i;
                  state_q <= ST_IDLE;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready_o = (state_q == ST_IDLE);
   assign list_idx_o  = idx_q;
   assign rsp_valid_o = rsp_v_q;
   assign rsp_data_o  = rsp_d_q;

endmodule

// File: rtl/rrsub_unit.sv
module rrsub_unit #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         req_valid,
   input  logic [W-1:0] req_data,
   output logic         req_ready,
   output logic         rsp_valid,
   output logic [W-1:0] rsp_data
);
   // only widths with a Fermat prime 2**W+1 and a bounded table
   generate
      if (W != 2 && W != 4 && W != 8) begin : g_bad_width
         $error("rrsub_unit: W must be 2, 4 or 8");
      end
   endgenerate

   logic         direct_hit;
   logic [W-1:0] direct_val;
   logic [W-2:0] list_idx;
   logic [W-1:0] list_pos;
   logic [W-1:0] list_val;

   rrsub_slot_table #(.W(W)) u_table (
      .addr_i   (req_data),
      .direct_o (direct_hit),
      .value_o  (direct_val)
   );

   rrsub_pair_list #(.W(W)) u_list (
      .idx_i (list_idx),
      .pos_o (list_pos),
      .val_o (list_val)
   );

   rrsub_search_ctrl #(.W(W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid_i  (req_valid),
      .req_data_i   (req_data),
      .req_ready_o  (req_ready),
      .direct_i     (direct_hit),
      .direct_val_i (direct_val),
      .list_idx_o   (list_idx),
      .list_pos_i   (list_pos),
      .list_val_i   (list_val),
      .rsp_valid_o  (rsp_valid),
      .rsp_data_o   (rsp_data)
   );

endmodule

// File: rtl/rrsub_unit_chk.sv
module rrsub_unit_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         req_valid,
   input logic [W-1:0] req_data,
   input logic         req_ready,
   input logic         rsp_valid,
   input logic [W-1:0] rsp_data
);
   localparam int unsigned BOUND = (1 << (W - 1)) + 1;

   logic         accept;
   logic         direct_ok;
   logic         pend_q;
   logic [W-1:0] key_q;
   int unsigned  wait_q;

   assign accept    = req_valid && req_ready;
   assign direct_ok = rrsub_pkg::resolves_direct(32'(req_data), W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         key_q  <= '0;
         wait_q <= 0;
      end else begin
         if (accept) begin
            pend_q <= 1'b1;
            key_q  <= req_data;
            wait_q <= 0;
         end else begin
            if (rsp_valid) pend_q <= 1'b0;
            if (pend_q && !rsp_valid) wait_q <= wait_q + 1;
         end
      end
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> (req_ready && !rsp_valid));

   assert_inverse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rrsub_pkg::is_inverse_pair(32'(rsp_data), 32'(key_q), W));

   assert_self_inverse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && key_q[W-1:1] == '0) |-> (rsp_data == key_q));

   assert_direct_next_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && direct_ok) |=> rsp_valid);

   assert_miss_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !direct_ok) |=> !req_ready);

   assert_busy_not_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !rsp_valid) |-> !req_ready);

   assert_search_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> (wait_q <= BOUND));

   assert_no_orphan_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> pend_q);

endmodule

bind rrsub_unit rrsub_unit_chk #(.W(W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .req_data  (req_data),
   .req_ready (req_ready),
   .rsp_valid (rsp_valid),
   .rsp_data  (rsp_data)
);

// File: tb/rrsub_unit_tb_top.sv
module rrsub_unit_tb_top;
   localparam int W  = 8;
   localparam int NB = 1 << W;
   localparam int PR = NB + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [W-1:0] req_data = '0;
   logic         req_ready;
   logic         rsp_valid;
   logic [W-1:0] rsp_data;

   always #2 clk = ~clk;   // 250 MHz

   rrsub_unit #(.W(W)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_data  (req_data),
      .req_ready (req_ready),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   int inv_t [NB];
   int lat_t [NB];
   int q_key [$];
   int q_val [$];
   int q_lat [$];
   int q_acc [$];
   int rsp_cnt = 0;
   int last_rsp = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string tag, int act, int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      int k, v, l, a;
      if (rst_n && rsp_valid) begin
         rsp_cnt++;
         last_rsp = int'(rsp_data);
         if (q_val.size() == 0) begin
            chk(1'b0, "R7 response without request", int'(rsp_data), -1);
         end else begin
            k = q_key.pop_front();
            v = q_val.pop_front();
            l = q_lat.pop_front();
            a = q_acc.pop_front();
            chk(int'(rsp_data) == v, (k < 2) ? "R3 self inverse" : "R2 inverse", int'(rsp_data), v);
            chk(cyc - a == l, (l == 0) ? "R4 direct latency" : "R5 search latency", cyc - a, l);
         end
      end
   end

   // driver: called at a falling edge, returns at the falling edge after acceptance
   task automatic push_req(int x);
      while (!req_ready) begin
         req_valid = 1'b0;
         @(negedge clk);
      end
      req_valid = 1'b1;
      req_data  = x[W-1:0];
      q_key.push_back(x);
      q_val.push_back(inv_t[x]);
      q_lat.push_back(lat_t[x]);
      q_acc.push_back(cyc + 1);
      @(negedge clk);
   endtask

   task automatic drain();
      while (q_val.size() != 0) @(negedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int worst;
      int cnt0;
      int y;
      // brute-force reference table and expected latencies
      for (int x = 0; x < NB; x++) begin
         int xn;
         xn = (x == 0) ? NB : x;
         for (int c = 1; c <= NB; c++)
            if ((xn * c) % PR == 1) inv_t[x] = (c == NB) ? 0 : c;
      end
      for (int x = 0; x < NB; x++) begin
         if (x < 2 || inv_t[x] > x) lat_t[x] = 0;
         else begin
            int rank;
            rank = 0;
            for (int z = 2; z < inv_t[x]; z++)
               if (inv_t[z] > z) rank++;
            lat_t[x] = rank + 1;
         end
      end
      worst = 2;
      for (int x = 0; x < NB; x++) if (lat_t[x] > lat_t[worst]) worst = x;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(req_ready && !rsp_valid, "R1 during reset", {req_ready, rsp_valid}, 2);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !rsp_valid, "R1 after release", {req_ready, rsp_valid}, 2);

      // R2 R3 R4 R5: ascending sweep, hits back to back
      for (int x = 0; x < NB; x++) push_req(x);
      req_valid = 1'b0;
      drain();

      // descending sweep
      for (int x = NB - 1; x >= 0; x--) push_req(x);
      req_valid = 1'b0;
      drain();

      // R6: substitution applied twice
      for (int x = 0; x < NB; x++) begin
         push_req(x);
         req_valid = 1'b0;
         drain();
         y = last_rsp;
         push_req(y);
         req_valid = 1'b0;
         drain();
         chk(last_rsp == x, "R6 involution", last_rsp, x);
      end

      // R8: competing request held during the longest search
      cnt0 = rsp_cnt;
      push_req(worst);
      for (int i = 0; i < 20; i++) begin
         req_valid = 1'b1;
         req_data  = 8'h02;
         chk(!req_ready, "R8 ready low while searching", int'(req_ready), 0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      drain();
      repeat (5) @(negedge clk);
      chk(rsp_cnt == cnt0 + 1, "R8 ignored request", rsp_cnt - cnt0, 1);

      // R1: reset in the middle of a search
      push_req(worst);
      req_valid = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b0;
      q_key.delete();
      q_val.delete();
      q_lat.delete();
      q_acc.delete();
      cnt0 = rsp_cnt;
      @(negedge clk);
      chk(req_ready && !rsp_valid, "R1 reset aborts search", {req_ready, rsp_valid}, 2);
      rst_n = 1'b1;
      repeat (200) @(negedge clk);
      chk(rsp_cnt == cnt0, "R1 no response after abort", rsp_cnt - cnt0, 0);
      push_req(5);
      req_valid = 1'b0;
      drain();
      chk(last_rsp == inv_t[5], "R1 recovery", last_rsp, inv_t[5]);
      chk(q_val.size() == 0, "R7 all requests answered", q_val.size(), 0);

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule